// File: doc/BRIEF.md
# Hashed requester-ID to stream-ID table

This block turns a 16-bit requester ID into an 8-bit stream ID that is relative to a base, for use by an address-translation unit. The requester ID is the bus, device and function number of a link transaction. The block holds 256 entries of 32 bits. Software loads them through a simple word-wide register port. A lookup port takes a requester ID and hashes it with CRC-8 to choose a starting slot. A small state machine then follows the per-entry link fields until the stored ID matches or the chain ends.

Each entry carries the requester ID in bits [31:16], the relative stream ID in bits [15:8] and the index of the next slot in bits [7:0]. A next index of zero ends a chain, and a word that is all zero is an empty slot. Software fills the table with linear probing. When the hash slot is already taken, it moves to the slot one higher, modulo 256. Each time it passes a chain tail whose next index is zero, it sets that next index to the slot it probes next. The table has no reset of its own, so software issues a clear before loading any mapping.

Top module: `rid_sid_table`

## Requirements
- R1: After reset, lk_ready is 1 and busy, res_valid and reg_ack are 0.
- R2: A register access is accepted in a cycle where reg_en is high and the block is idle. reg_ack is high for exactly one cycle after the accepting clock edge. On a write (reg_we=1), the word is stored at reg_addr. On a read, reg_rdata shows the stored word while reg_ack is high.
- R3: The start slot is CRC-8 of the requester ID, taken high byte first and MSB first. The polynomial is 0x07, the initial value is 0, there is no reflection and no final XOR. For example, ID 0x0001 starts at slot 0x07.
- R4: When the entry under examination is not zero and its bits [31:16] equal the requested ID, the result is res_hit=1 with res_sid equal to the entry's bits [15:8].
- R5: When the entry is not zero, its ID differs from the request and its bits [7:0] are not zero, the walk continues at the slot given by bits [7:0].
- R6: An all-zero entry, or an entry whose ID differs and whose bits [7:0] are zero, ends the walk with res_hit=0 and res_sid=0.
- R7: A walk examines at most 256 entries. A cyclic chain that holds no match ends with a miss after 256 examined entries.
- R8: lk_ready falls in the cycle after a request is accepted and returns only once the result is out. res_valid is a pulse of exactly one cycle.
- R9: When a register access and a lookup request arrive in the same cycle, the lookup is taken first. The register access is acknowledged only after the lookup result.
- R10: A one-cycle pulse on clr_start while idle raises busy for exactly 256 cycles. During that time lk_ready is 0. Afterwards every entry reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| reg_en | input | 1 | Register access request; held until reg_ack |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Entry index |
| reg_wdata | input | 32 | Entry word to write |
| reg_rdata | output | 32 | Entry word read, valid with reg_ack |
| reg_ack | output | 1 | One-cycle acknowledge of a register access |
| clr_start | input | 1 | Pulse to zero the whole table |
| busy | output | 1 | Clear in progress |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be taken |
| lk_id | input | 16 | Requester ID to look up |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | 1 when a matching entry was found |
| res_sid | output | 8 | Relative stream ID on a hit, 0 on a miss |

## Verification
A wrong start slot, a wrong link fetch or a wrong compare shows up at the next res_valid. It appears as a flipped res_hit or a wrong res_sid, one cycle per entry examined after acceptance, so a single mismatch is caught within a few cycles of the request. A step counter that fails to stop, or that stops too early, shows as a missing or premature result on a cyclic chain. A wrong latency there, against the expected 256 entries, exposes it at once. A clear that is too short or too long shows in the length of busy. Any entry it skips shows as a non-zero read-back, and a lookup that was let in during the clear shows as lk_ready going high too early.

// File: rtl/rid_sid_table.sv
`timescale 1ns/1ps
module rid_sid_table #(
  parameter int ID_W  = 16,
  parameter int SID_W = 8,
  parameter int IDX_W = 8,
  parameter logic [IDX_W-1:0] POLY = 8'h07
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_en,
  input  logic                          reg_we,
  input  logic [IDX_W-1:0]              reg_addr,
  input  logic [ID_W+SID_W+IDX_W-1:0]   reg_wdata,
  output logic [ID_W+SID_W+IDX_W-1:0]   reg_rdata,
  output logic                          reg_ack,
  input  logic                          clr_start,
  output logic                          busy,
  input  logic                          lk_valid,
  output logic                          lk_ready,
  input  logic [ID_W-1:0]               lk_id,
  output logic                          res_valid,
  output logic                          res_hit,
  output logic [SID_W-1:0]              res_sid
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = ID_W + SID_W + IDX_W;

  typedef enum logic {S_IDLE, S_WALK} st_t;

  function automatic logic [IDX_W-1:0] slot_of(input logic [ID_W-1:0] id);
    logic [IDX_W-1:0] c;
    c = '0;
    for (int i = ID_W - 1; i >= 0; i--) begin
      if (c[IDX_W-1] ^ id[i]) c = {c[IDX_W-2:0], 1'b0} ^ POLY;
      else                    c = {c[IDX_W-2:0], 1'b0};
    end
    return c;
  endfunction

  logic [ENT_W-1:0] mem [DEPTH];
  st_t              st;
  logic [IDX_W-1:0] ptr, steps, cptr;
  logic [ID_W-1:0]  key;
  logic             clearing;

  wire idle   = (st == S_IDLE) && !clearing;
  wire lk_go  = lk_valid && lk_ready;
  wire clr_go = clr_start && idle;
  wire reg_go = reg_en && !reg_ack && idle && !clr_start && !lk_valid;

  assign busy     = clearing;
  assign lk_ready = idle && !clr_start;

  wire [ENT_W-1:0] cur     = mem[ptr];
  wire [ID_W-1:0]  cur_id  = cur[ENT_W-1 -: ID_W];
  wire [SID_W-1:0] cur_sid = cur[IDX_W +: SID_W];
  wire [IDX_W-1:0] cur_nxt = cur[IDX_W-1:0];
  wire empty = (cur == '0);
  wire match = !empty && (cur_id == key);
  wire stop  = empty || match || (cur_nxt == '0) || (steps == IDX_W'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_sid   <= '0;
      reg_ack   <= 1'b0;
      clearing  <= 1'b0;
      cptr      <= '0;
    end else begin
      res_valid <= 1'b0;
      reg_ack   <= reg_go;
      if (lk_go) begin
        st    <= S_WALK;
        ptr   <= slot_of(lk_id);
        key   <= lk_id;
        steps <= '0;
      end else if (st == S_WALK) begin
        if (stop) begin
          st        <= S_IDLE;
          res_valid <= 1'b1;
          res_hit   <= match;
          res_sid   <= match ? cur_sid : '0;
        end else begin
          ptr   <= cur_nxt;
          steps <= steps + 1'b1;
        end
      end
      if (clr_go) begin
        clearing <= 1'b1;
        cptr     <= '0;
      end else if (clearing) begin
        cptr <= cptr + 1'b1;
        if (cptr == IDX_W'(DEPTH - 1)) clearing <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clearing)              mem[cptr]     <= '0;
    else if (reg_go && reg_we) mem[reg_addr] <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_go) reg_rdata <= mem[reg_addr];
  end

  // R8
  lk_single_chk: assert property (@(posedge clk) disable iff (!rst_n) lk_go |=> !lk_ready);
  // R8
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid);
  // R2
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_ack |=> !reg_ack);
  // R9
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_ack |-> $past(st == S_IDLE));
  // R10
  clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (st == S_IDLE) && !res_valid);
endmodule

// File: tb/test_rid_sid_table.sv
`timescale 1ns/1ps
module test_rid_sid_table;
  logic        clk = 0, rst_n = 0;
  logic        reg_en = 0, reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        reg_ack, clr_start = 0, busy;
  logic        lk_valid = 0, lk_ready;
  logic [15:0] lk_id = 0;
  logic        res_valid, res_hit;
  logic [7:0]  res_sid;

  int checks = 0, fails = 0;
  bit [31:0] model [256];

  always #2.5 clk = ~clk;

  rid_sid_table i_rid_sid_table (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack), .clr_start(clr_start),
    .busy(busy), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_id(lk_id),
    .res_valid(res_valid), .res_hit(res_hit), .res_sid(res_sid));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit [7:0] crc_ref(input bit [15:0] id);
    bit [7:0] c = 8'h00;
    bit [7:0] bytes [2];
    bytes[0] = id[15:8];
    bytes[1] = id[7:0];
    for (int b = 0; b < 2; b++) begin
      c = c ^ bytes[b];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c;
  endfunction

  function automatic void model_find(input bit [15:0] id, output bit hit,
                                     output bit [7:0] sid, output int seen);
    bit [7:0] p = crc_ref(id);
    hit = 0; sid = 0; seen = 0;
    for (int s = 0; s < 256; s++) begin
      seen++;
      if (model[p] == 0) return;
      if (model[p][31:16] == id) begin hit = 1; sid = model[p][15:8]; return; end
      if (model[p][7:0] == 0) return;
      p = model[p][7:0];
    end
  endfunction

  task automatic reg_acc(input bit we, input bit [7:0] a, input bit [31:0] d,
                         output bit [31:0] q);
    @(negedge clk);
    reg_en = 1; reg_we = we; reg_addr = a; reg_wdata = d;
    do @(negedge clk); while (!reg_ack);
    q = reg_rdata;
    reg_en = 0; reg_we = 0;
  endtask

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    bit [31:0] q;
    reg_acc(1, a, d, q);
    model[a] = d;
  endtask

  task automatic lookup(input bit [15:0] id, output bit hit, output bit [7:0] sid,
                        output int lat);
    @(negedge clk);
    lk_id = id; lk_valid = 1;
    while (!lk_ready) @(negedge clk);
    @(negedge clk);
    lk_valid = 0; lat = 1;
    chk(!lk_ready, "R8", "lk_ready after accept", lk_ready, 0);
    while (!res_valid && lat < 1000) begin @(negedge clk); lat++; end
    hit = res_hit; sid = res_sid;
    @(negedge clk);
    chk(!res_valid, "R8", "res_valid pulse width", res_valid, 0);
  endtask

  task automatic lookup_chk(input bit [15:0] id, input string req);
    bit h, eh; bit [7:0] s, es; int lat, seen;
    model_find(id, eh, es, seen);
    lookup(id, h, s, lat);
    chk(h == eh, req, $sformatf("hit for id %h", id), h, eh);
    chk(s == es, req, $sformatf("sid for id %h", id), s, es);
  endtask

  task automatic clear_all();
    int n = 0; bit rdy_seen = 0;
    @(negedge clk); clr_start = 1;
    @(negedge clk); clr_start = 0;
    while (busy && n < 1000) begin
      if (lk_ready) rdy_seen = 1;
      n++;
      @(negedge clk);
    end
    chk(n == 256, "R10", "busy length", n, 256);
    chk(!rdy_seen, "R10", "lk_ready during clear", rdy_seen, 0);
    for (int i = 0; i < 256; i++) model[i] = 0;
  endtask

  task automatic insert(input bit [15:0] id, input bit [7:0] sid);
    bit [7:0] h = crc_ref(id);
    while (model[h] != 0) begin
      if (model[h][7:0] == 0) wr(h, model[h] | {24'd0, h + 8'd1});
      h = h + 8'd1;
    end
    wr(h, {id, sid, 8'd0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit [31:0] q; bit h, eh; bit [7:0] s, es; int lat, seen;
    bit [15:0] ids [40];
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(lk_ready == 1, "R1", "lk_ready after reset", lk_ready, 1);
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(res_valid == 0, "R1", "res_valid after reset", res_valid, 0);
    chk(reg_ack == 0, "R1", "reg_ack after reset", reg_ack, 0);

    clear_all();
    reg_acc(0, 8'h3c, 0, q);
    chk(q == 0, "R10", "entry 3c after clear", q, 0);
    reg_acc(0, 8'hff, 0, q);
    chk(q == 0, "R10", "entry ff after clear", q, 0);

    // R2 write and read back
    wr(8'h11, 32'hdead_be00);
    reg_acc(0, 8'h11, 0, q);
    chk(q == 32'hdead_be00, "R2", "read back", q, 32'hdead_be00);
    wr(8'h11, 0);

    // R3 known start slot, R4 hit
    chk(crc_ref(16'h0001) == 8'h07, "R3", "reference crc", crc_ref(16'h0001), 8'h07);
    wr(8'h07, {16'h0001, 8'h5a, 8'h00});
    lookup(16'h0001, h, s, lat);
    chk(h == 1 && s == 8'h5a, "R3", "hit at slot 07", {h, s}, {1'b1, 8'h5a});
    chk(lat == 2, "R4", "direct hit latency", lat, 2);

    // R6 mismatch with zero next, and empty slot
    lookup_chk(16'h0101, "R6");
    wr(8'h07, 0);
    lookup(16'h0001, h, s, lat);
    chk(h == 0 && s == 0, "R6", "empty slot miss", {h, s}, 0);

    // R5 chain follow
    begin
      bit [7:0] hx = crc_ref(16'hbeef);
      wr(hx, {16'h1234, 8'h01, hx + 8'd3});
      wr(hx + 8'd3, {16'hbeef, 8'h33, 8'h00});
      lookup(16'hbeef, h, s, lat);
      chk(h == 1 && s == 8'h33, "R5", "hit after one jump", {h, s}, {1'b1, 8'h33});
      chk(lat == 3, "R5", "one jump latency", lat, 3);
      // R7 cyclic chain
      wr(hx + 8'd3, {16'h4321, 8'h02, hx});
      lookup(16'hbeef, h, s, lat);
      chk(h == 0 && s == 0, "R7", "cyclic chain miss", {h, s}, 0);
      chk(lat == 257, "R7", "cyclic chain latency", lat, 257);
    end

    // R9 lookup wins over register access
    begin
      int t = 0, t_res = -1, t_ack = -1;
      @(negedge clk);
      lk_id = 16'h0777; lk_valid = 1;
      reg_en = 1; reg_we = 0; reg_addr = 8'h00;
      @(negedge clk);
      lk_valid = 0;
      while ((t_res < 0 || t_ack < 0) && t < 600) begin
        if (res_valid && t_res < 0) t_res = t;
        if (reg_ack && t_ack < 0) begin t_ack = t; reg_en = 0; end
        t++;
        @(negedge clk);
      end
      reg_en = 0;
      chk(t_res >= 0 && t_ack > t_res, "R9", "ack after result", t_ack, t_res + 1);
    end

    // random fill with linear probing, then lookups
    clear_all();
    for (int i = 0; i < 40; i++) begin
      do begin
        ids[i] = 16'($urandom);
        model_find(ids[i], eh, es, seen);
      end while (ids[i] == 0 || eh);
      insert(ids[i], 8'($urandom));
    end
    for (int i = 0; i < 40; i++) lookup_chk(ids[i], "R4");
    for (int i = 0; i < 40; i++) lookup_chk(16'($urandom), "R6");
    for (int i = 0; i < 8; i++) begin
      bit [7:0] a = 8'($urandom);
      reg_acc(0, a, 0, q);
      chk(q == model[a], "R2", $sformatf("random read %h", a), q, model[a]);
    end

    // R10 clear wipes the mappings
    clear_all();
    lookup(ids[0], h, s, lat);
    chk(h == 0, "R10", "miss after clear", h, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule